// File: doc/BRIEF.md
# Buffered I2C Master Transfer Sequencer

This block sits between a host and a byte-level I2C engine. It runs whole multi-byte master transfers out of a local byte buffer, so the host gets one interrupt per transfer run instead of one per byte. The host loads bytes into the buffer and programs a byte count together with a last-byte flag. It then writes a small control word that asks for a START, a STOP, or the next run. Each finished step posts a one-byte status code, and the count register is overwritten with the number of bytes that actually moved.

The byte engine is driven through a request/acknowledge pair. The sequencer holds `eng_req` high with a stable command until the engine returns a one-cycle `eng_ack`. The engine reports a missing slave acknowledge on `eng_nack` and returns received bytes on `eng_rdata`. Bit timing, arbitration and slave operation belong to the byte engine or are not handled here. While the sequencer is waiting for the host, it issues no command, which leaves the clock line held low by the engine.

Top module: `bseq_master`

## Requirements
- R1: A control write is acted on only when its enable bit (bit 0) is 1. A write with bit 0 clear changes neither the status, the interrupt nor the commands issued. Control bits: bit 0 enable, bit 1 start, bit 2 stop, bit 3 interrupt flag.
- R2: When the bus is not owned, a control write with start set and stop clear issues command START (code 0). When it completes, the interrupt rises and the status reads 08h.
- R3: When the bus is owned and the sequencer is waiting for the host, a start write issues command RSTART (code 1). When it completes, the interrupt rises and the status reads 10h.
- R4: After a start, a write with start, stop and interrupt flag all clear begins a run. If bit 0 of buffer entry 0 is 0, the run sends `count` buffer entries in order from entry 0 with command WRITE (code 2). When all are acknowledged, the status reads 28h and the count field holds the number sent.
- R5: If bit 0 of buffer entry 0 is 1, entry 0 is sent as the address and then `count` bytes are received. Each is received with READ_ACK (code 3), except that the final byte uses READ_NACK (code 4) when the last-byte flag (count register bit 7) is 1. The status reads 58h with the flag set and 50h without it. The received bytes are then readable from buffer entry 0 onward.
- R6: A run write issued while the bus is still owned after a completed run continues in the same direction, with no START and no address byte.
- R7: A write with stop set issues command STOP (code 5). After it completes, the interrupt stays low, the status reads F8h and the bus is no longer owned.
- R8: A slave NACK ends a run at once and raises the interrupt. A NACK on the address byte reads 20h with count 0. A NACK on a later byte reads 30h with the count of bytes that were acknowledged.
- R9: A count write resets the host buffer pointer to entry 0. Host writes and reads then advance through the buffer in order. The pointer also returns to entry 0 when a run ends.
- R10: Control and count writes that arrive while a command is in flight are dropped, including one that arrives in the same cycle as the final acknowledge.
- R11: After reset the status is F8h, the interrupt is low, no command is requested and the count register is 0.
- R12: While the interrupt is high, no command is requested.
- R13: A control write with both start and stop set performs the stop only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ctl_wr | input | 1 | Control word write strobe |
| host_ctl_data | input | 4 | Control word: enable, start, stop, interrupt flag |
| host_cnt_wr | input | 1 | Count register write strobe |
| host_cnt_data | input | 8 | Bit 7 last-byte flag, bits 6:0 byte count |
| host_buf_wr | input | 1 | Buffer write at host pointer |
| host_buf_wdata | input | 8 | Buffer write data |
| host_buf_rd | input | 1 | Advance host pointer after a read |
| host_buf_rdata | output | 8 | Buffer entry at host pointer |
| status_code | output | 8 | Status byte of the last completed step |
| xfer_count | output | 8 | Last-byte flag and programmed or transferred count |
| irq | output | 1 | Interrupt, high while waiting for the host |
| eng_req | output | 1 | Command request to byte engine |
| eng_cmd | output | 3 | Command code |
| eng_wdata | output | 8 | Byte to send |
| eng_ack | input | 1 | Command done, one cycle |
| eng_nack | input | 1 | Slave did not acknowledge the byte sent |
| eng_rdata | input | 8 | Received byte, valid with eng_ack |

## Verification
The collision of interest is a host control write landing in the same clock cycle as the engine's acknowledge of the last byte of a run. The bench waits until it sees `eng_ack` high, then drives a stop write so that both are sampled on the same edge. It expects the run to finish normally with status 28h, no STOP command in the engine log, and the interrupt raised. A later stop write must then take effect. Random runs of mixed direction, length, last-byte flag and NACK position are checked the same way against a command log kept by the engine model.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

    localparam int CNT_W = 7;

    typedef enum logic [2:0] {
        CMD_START   = 3'd0,
        CMD_RSTART  = 3'd1,
        CMD_WRITE   = 3'd2,
        CMD_RD_ACK  = 3'd3,
        CMD_RD_NACK = 3'd4,
        CMD_STOP    = 3'd5
    } eng_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_ADDR,
        ST_TX,
        ST_RX,
        ST_STOP
    } seq_state_e;

    typedef struct packed {
        logic si;
        logic sto;
        logic sta;
        logic en;
    } ctl_word_t;

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] num;
    } cnt_word_t;

    localparam logic [7:0] SC_START     = 8'h08;
    localparam logic [7:0] SC_RSTART    = 8'h10;
    localparam logic [7:0] SC_ADDR_NACK = 8'h20;
    localparam logic [7:0] SC_TX_DONE   = 8'h28;
    localparam logic [7:0] SC_DATA_NACK = 8'h30;
    localparam logic [7:0] SC_RX_ACK    = 8'h50;
    localparam logic [7:0] SC_RX_NACK   = 8'h58;
    localparam logic [7:0] SC_IDLE      = 8'hF8;

    function automatic logic [7:0] rx_end_code(input logic last);
        return last ? SC_RX_NACK : SC_RX_ACK;
    endfunction

    function automatic logic [7:0] tx_nack_code(input logic addr_byte);
        return addr_byte ? SC_ADDR_NACK : SC_DATA_NACK;
    endfunction

endpackage

// File: rtl/bseq_buffer.sv
`timescale 1ns/1ps
module bseq_buffer #(
    parameter int DEPTH = 68,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_clr,
    input  logic             h_we,
    input  logic [7:0]       h_wdata,
    input  logic             h_re,
    output logic [7:0]       h_rdata,
    input  logic [PTR_W-1:0] e_raddr,
    output logic [7:0]       e_rdata,
    input  logic             e_we,
    input  logic [PTR_W-1:0] e_waddr,
    input  logic [7:0]       e_wdata
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] hptr;
    logic [PTR_W-1:0] hptr_nxt;

    assign hptr_nxt = (hptr == LAST_IDX) ? '0 : hptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            hptr <= '0;
        else if (ptr_clr)
            hptr <= '0;
        else if (h_we || h_re)
            hptr <= hptr_nxt;
    end

    // engine write placed last so it wins a same-entry collision
    always_ff @(posedge clk) begin
        if (h_we && !ptr_clr)
            mem[hptr] <= h_wdata;
        if (e_we)
            mem[e_waddr] <= e_wdata;
    end

    assign h_rdata = mem[hptr];
    assign e_rdata = mem[e_raddr];

    a_r9_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
        ((h_we || h_re) && !ptr_clr && hptr == LAST_IDX) |=> (hptr == '0));

    a_r9_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
        ptr_clr |=> (hptr == '0));

endmodule

// File: rtl/bseq_ctrl.sv
`timescale 1ns/1ps
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_data,
    input  logic             cnt_wr,
    input  logic [7:0]       cnt_data,
    output logic             eng_req,
    output logic [2:0]       eng_cmd,
    output logic [7:0]       eng_wdata,
    input  logic             eng_ack,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    output logic [PTR_W-1:0] buf_raddr,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [PTR_W-1:0] buf_waddr,
    output logic [7:0]       buf_wdata,
    output logic             ptr_clr,
    output logic [7:0]       status,
    output logic [7:0]       count_word,
    output logic             irq
);

    seq_state_e       state;
    ctl_word_t        cw;
    cnt_word_t        cnt_q;
    logic [CNT_W-1:0] idx;
    logic             si_q;
    logic             owned;
    logic             addr_pend;
    logic             rx_dir;
    logic             accept;
    logic             ctl_ok;
    logic             cnt_ok;
    logic             at_end;
    logic             last_rd;
    logic             done;
    logic             seq_fin;
    eng_cmd_e         cmd;

    assign cw      = ctl_word_t'(ctl_data);
    assign accept  = (state == ST_IDLE) || (state == ST_HOLD);
    assign ctl_ok  = ctl_wr && cw.en && accept;
    assign cnt_ok  = cnt_wr && accept;
    assign at_end  = (idx == cnt_q.num);
    assign last_rd = ({1'b0, idx} + 8'd1) == {1'b0, cnt_q.num};
    assign done    = eng_req && eng_ack;

    always_comb begin
        eng_req   = 1'b0;
        cmd       = CMD_WRITE;
        buf_raddr = '0;
        case (state)
            ST_START: begin
                eng_req = 1'b1;
                cmd     = owned ? CMD_RSTART : CMD_START;
            end
            ST_ADDR: eng_req = 1'b1;
            ST_TX: begin
                buf_raddr = PTR_W'(idx);
                eng_req   = !at_end;
            end
            ST_RX: begin
                eng_req = !at_end;
                cmd     = (cnt_q.last && last_rd) ? CMD_RD_NACK : CMD_RD_ACK;
            end
            ST_STOP: begin
                eng_req = 1'b1;
                cmd     = CMD_STOP;
            end
            default: ;
        endcase
    end

    assign eng_cmd   = cmd;
    assign eng_wdata = buf_rdata;
    assign buf_we    = (state == ST_RX) && done;
    assign buf_waddr = PTR_W'(idx);
    assign buf_wdata = eng_rdata;

    assign seq_fin = (((state == ST_TX) || (state == ST_RX)) && at_end)
                   || ((state == ST_ADDR) && done && eng_nack)
                   || ((state == ST_TX) && done && eng_nack);
    assign ptr_clr = cnt_ok || seq_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt_q     <= '0;
            idx       <= '0;
            si_q      <= 1'b0;
            owned     <= 1'b0;
            addr_pend <= 1'b0;
            rx_dir    <= 1'b0;
            status    <= SC_IDLE;
        end else begin
            if (cnt_ok)
                cnt_q <= cnt_word_t'(cnt_data);
            case (state)
                ST_IDLE: begin
                    if (ctl_ok && cw.sta && !cw.sto)
                        state <= ST_START;
                end
                ST_HOLD: begin
                    if (ctl_ok) begin
                        if (cw.sto) begin
                            si_q  <= 1'b0;
                            state <= ST_STOP;
                        end else if (cw.sta) begin
                            si_q  <= 1'b0;
                            state <= ST_START;
                        end else if (!cw.si) begin
                            si_q <= 1'b0;
                            idx  <= '0;
                            if (addr_pend) begin
                                rx_dir <= buf_rdata[0];
                                state  <= buf_rdata[0] ? ST_ADDR : ST_TX;
                            end else begin
                                state <= rx_dir ? ST_RX : ST_TX;
                            end
                        end
                    end
                end
                ST_START: begin
                    if (done) begin
                        owned     <= 1'b1;
                        status    <= owned ? SC_RSTART : SC_START;
                        si_q      <= 1'b1;
                        addr_pend <= 1'b1;
                        state     <= ST_HOLD;
                    end
                end
                ST_ADDR: begin
                    if (done) begin
                        addr_pend <= 1'b0;
                        if (eng_nack) begin
                            status    <= SC_ADDR_NACK;
                            cnt_q.num <= '0;
                            si_q      <= 1'b1;
                            state     <= ST_HOLD;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (at_end) begin
                        status    <= SC_TX_DONE;
                        cnt_q.num <= idx;
                        si_q      <= 1'b1;
                        addr_pend <= 1'b0;
                        state     <= ST_HOLD;
                    end else if (done) begin
                        if (eng_nack) begin
                            status    <= tx_nack_code(addr_pend && (idx == '0));
                            cnt_q.num <= idx;
                            si_q      <= 1'b1;
                            addr_pend <= 1'b0;
                            state     <= ST_HOLD;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (at_end) begin
                        status    <= rx_end_code(cnt_q.last);
                        cnt_q.num <= idx;
                        si_q      <= 1'b1;
                        state     <= ST_HOLD;
                    end else if (done) begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (done) begin
                        owned     <= 1'b0;
                        addr_pend <= 1'b0;
                        status    <= SC_IDLE;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign irq        = si_q;
    assign count_word = cnt_q;

    a_r1_mode_gate: assert property (@(posedge clk) disable iff (rst)
        (accept && ctl_wr && !ctl_data[0] && !cnt_wr) |=> ($stable(state) && $stable(si_q)));

    a_r2_start_code: assert property (@(posedge clk) disable iff (rst)
        (done && eng_cmd == CMD_START) |=> (irq && status == SC_START));

    a_r3_rstart_code: assert property (@(posedge clk) disable iff (rst)
        (done && eng_cmd == CMD_RSTART) |=> (irq && status == SC_RSTART));

    a_r7_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (done && eng_cmd == CMD_STOP) |=> (!irq && status == SC_IDLE && !eng_req));

    a_r8_nack_ends_run: assert property (@(posedge clk) disable iff (rst)
        (done && eng_nack && eng_cmd == CMD_WRITE)
        |=> (irq && (status == SC_ADDR_NACK || status == SC_DATA_NACK)));

    a_r10_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_cmd)));

    a_r12_hold_idle_bus: assert property (@(posedge clk) disable iff (rst)
        irq |-> !eng_req);

endmodule

// File: rtl/bseq_master.sv
`timescale 1ns/1ps
module bseq_master
    import bseq_pkg::*;
#(
    parameter int DEPTH = 68
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_ctl_wr,
    input  logic [3:0] host_ctl_data,
    input  logic       host_cnt_wr,
    input  logic [7:0] host_cnt_data,
    input  logic       host_buf_wr,
    input  logic [7:0] host_buf_wdata,
    input  logic       host_buf_rd,
    output logic [7:0] host_buf_rdata,
    output logic [7:0] status_code,
    output logic [7:0] xfer_count,
    output logic       irq,
    output logic       eng_req,
    output logic [2:0] eng_cmd,
    output logic [7:0] eng_wdata,
    input  logic       eng_ack,
    input  logic       eng_nack,
    input  logic [7:0] eng_rdata
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] buf_raddr;
    logic [PTR_W-1:0] buf_waddr;
    logic [7:0]       buf_rdata;
    logic [7:0]       buf_wdata;
    logic             buf_we;
    logic             ptr_clr;

    bseq_buffer #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .ptr_clr (ptr_clr),
        .h_we    (host_buf_wr),
        .h_wdata (host_buf_wdata),
        .h_re    (host_buf_rd),
        .h_rdata (host_buf_rdata),
        .e_raddr (buf_raddr),
        .e_rdata (buf_rdata),
        .e_we    (buf_we),
        .e_waddr (buf_waddr),
        .e_wdata (buf_wdata)
    );

    bseq_ctrl #(
        .PTR_W (PTR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (host_ctl_wr),
        .ctl_data   (host_ctl_data),
        .cnt_wr     (host_cnt_wr),
        .cnt_data   (host_cnt_data),
        .eng_req    (eng_req),
        .eng_cmd    (eng_cmd),
        .eng_wdata  (eng_wdata),
        .eng_ack    (eng_ack),
        .eng_nack   (eng_nack),
        .eng_rdata  (eng_rdata),
        .buf_raddr  (buf_raddr),
        .buf_rdata  (buf_rdata),
        .buf_we     (buf_we),
        .buf_waddr  (buf_waddr),
        .buf_wdata  (buf_wdata),
        .ptr_clr    (ptr_clr),
        .status     (status_code),
        .count_word (xfer_count),
        .irq        (irq)
    );

endmodule

// File: tb/bseq_master_tb.sv
`timescale 1ns/1ps
module bseq_master_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_ctl_wr = 1'b0;
    logic [3:0] host_ctl_data = '0;
    logic       host_cnt_wr = 1'b0;
    logic [7:0] host_cnt_data = '0;
    logic       host_buf_wr = 1'b0;
    logic [7:0] host_buf_wdata = '0;
    logic       host_buf_rd = 1'b0;
    logic [7:0] host_buf_rdata;
    logic [7:0] status_code;
    logic [7:0] xfer_count;
    logic       irq;
    logic       eng_req;
    logic [2:0] eng_cmd;
    logic [7:0] eng_wdata;
    logic       eng_ack;
    logic       eng_nack;
    logic [7:0] eng_rdata;

    always #2.5 clk = ~clk;

    bseq_master u_dut (
        .clk(clk), .rst(rst),
        .host_ctl_wr(host_ctl_wr), .host_ctl_data(host_ctl_data),
        .host_cnt_wr(host_cnt_wr), .host_cnt_data(host_cnt_data),
        .host_buf_wr(host_buf_wr), .host_buf_wdata(host_buf_wdata),
        .host_buf_rd(host_buf_rd), .host_buf_rdata(host_buf_rdata),
        .status_code(status_code), .xfer_count(xfer_count), .irq(irq),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
        .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [2:0] log_cmd [0:2047];
    logic [7:0] log_dat [0:2047];
    int log_n;
    int wr_seen;
    int wcnt;
    int nack_at = -1;
    int lat = 1;
    logic [7:0] txb [0:15];

    // byte engine model with command log
    always @(posedge clk) begin
        if (rst) begin
            eng_ack <= 1'b0; eng_nack <= 1'b0; eng_rdata <= '0;
            wcnt <= 0; log_n <= 0; wr_seen <= 0;
        end else begin
            eng_ack <= 1'b0;
            if (eng_req && eng_ack) begin
                if (log_n < 2048) begin
                    log_cmd[log_n] <= eng_cmd;
                    log_dat[log_n] <= (eng_cmd == 3'd2) ? eng_wdata : eng_rdata;
                end
                log_n <= log_n + 1;
            end else if (eng_req) begin
                if (wcnt >= lat) begin
                    eng_ack   <= 1'b1;
                    wcnt      <= 0;
                    eng_rdata <= 8'($urandom);
                    eng_nack  <= (eng_cmd == 3'd2) && (wr_seen == nack_at);
                    if (eng_cmd == 3'd2) wr_seen <= wr_seen + 1;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            summary_and_end();
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_tx_stat(input int c, input int k, input bit first);
        if (k < 0 || k >= c) return 'h28;
        return (first && k == 0) ? 'h20 : 'h30;
    endfunction

    function automatic int exp_tx_cnt(input int c, input int k);
        return (k < 0 || k >= c) ? c : k;
    endfunction

    task automatic ctl_write(input logic [3:0] d);
        @(negedge clk); host_ctl_wr = 1'b1; host_ctl_data = d;
        @(negedge clk); host_ctl_wr = 1'b0;
    endtask

    task automatic cnt_write(input int c, input bit last);
        @(negedge clk); host_cnt_wr = 1'b1; host_cnt_data = {last, 7'(c)};
        @(negedge clk); host_cnt_wr = 1'b0;
    endtask

    task automatic buf_load(input logic [7:0] b);
        @(negedge clk); host_buf_wr = 1'b1; host_buf_wdata = b;
        @(negedge clk); host_buf_wr = 1'b0;
    endtask

    task automatic buf_read(output logic [7:0] b);
        @(negedge clk); b = host_buf_rdata; host_buf_rd = 1'b1;
        @(negedge clk); host_buf_rd = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 400) begin @(negedge clk); n++; end
        if (!irq) check_eq({tag, " irq"}, 0, 1);
    endtask

    task automatic hold_quiet(input string tag);
        repeat (3) begin
            @(negedge clk);
            check_eq({tag, " R12 no request while irq"}, int'(eng_req), 0);
        end
    endtask

    task automatic do_start(input bit owned);
        int mark = log_n;
        ctl_write(4'b0011);
        wait_irq("R2/R3 start");
        check_eq(owned ? "R3 rstart status" : "R2 start status",
                 int'(status_code), owned ? 'h10 : 'h08);
        check_eq(owned ? "R3 rstart cmd" : "R2 start cmd",
                 int'(log_cmd[mark]), owned ? 1 : 0);
    endtask

    task automatic do_stop();
        int mark = log_n;
        ctl_write(4'b0101);
        repeat (12) @(negedge clk);
        check_eq("R7 stop cmd", int'(log_cmd[mark]), 5);
        check_eq("R7 stop count", log_n - mark, 1);
        check_eq("R7 idle status", int'(status_code), 'hF8);
        check_eq("R7 no irq", int'(irq), 0);
    endtask

    task automatic do_tx(input int c, input int k, input bit first, output bit nacked);
        int mark;
        int n;
        for (int i = 0; i < c; i++) txb[i] = 8'($urandom);
        if (first) txb[0][0] = 1'b0;
        cnt_write(c, 1'b0);
        for (int i = 0; i < c; i++) buf_load(txb[i]);
        nack_at = (k >= 0) ? wr_seen + k : -1;
        mark = log_n;
        ctl_write(4'b0001);
        wait_irq("R4 tx");
        nack_at = -1;
        n = (k >= 0 && k < c) ? k + 1 : c;
        check_eq(first ? "R4 tx byte total" : "R6 chained tx byte total", log_n - mark, n);
        for (int i = 0; i < n; i++) begin
            check_eq("R4 tx cmd", int'(log_cmd[mark + i]), 2);
            check_eq("R4 tx data order", int'(log_dat[mark + i]), int'(txb[i]));
        end
        check_eq((k >= 0 && k < c) ? "R8 nack status" : "R4 tx status",
                 int'(status_code), exp_tx_stat(c, k, first));
        check_eq((k >= 0 && k < c) ? "R8 nack count" : "R4 tx count",
                 int'(xfer_count[6:0]), exp_tx_cnt(c, k));
        hold_quiet("tx");
        nacked = (k >= 0 && k < c);
    endtask

    task automatic do_rx(input int c, input bit last, input bit with_addr, input bit addr_nack);
        int mark;
        int base;
        logic [7:0] a;
        logic [7:0] rb;
        a = {7'($urandom), 1'b1};
        cnt_write(c, last);
        if (with_addr) buf_load(a);
        nack_at = addr_nack ? wr_seen : -1;
        mark = log_n;
        ctl_write(4'b0001);
        wait_irq("R5 rx");
        nack_at = -1;
        base = mark;
        if (with_addr) begin
            check_eq("R5 rx address cmd", int'(log_cmd[mark]), 2);
            check_eq("R5 rx address byte", int'(log_dat[mark]), int'(a));
            base = mark + 1;
            if (addr_nack) begin
                check_eq("R8 addr nack status", int'(status_code), 'h20);
                check_eq("R8 addr nack count", int'(xfer_count[6:0]), 0);
                return;
            end
        end else begin
            check_eq("R6 chained rx no start", int'(log_cmd[mark] == 3'd0 || log_cmd[mark] == 3'd1), 0);
        end
        check_eq("R5 rx byte total", log_n - base, c);
        for (int i = 0; i < c; i++)
            check_eq("R5 rx ack/nack cmd", int'(log_cmd[base + i]), (last && i == c - 1) ? 4 : 3);
        check_eq("R5 rx status", int'(status_code), last ? 'h58 : 'h50);
        check_eq("R5 rx count", int'(xfer_count[6:0]), c);
        hold_quiet("rx");
        for (int i = 0; i < c; i++) begin
            buf_read(rb);
            check_eq("R5 R9 rx data readback", int'(rb), int'(log_dat[base + i]));
        end
    endtask

    initial begin
        bit owned;
        bit nk;
        int mark;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check_eq("R11 reset status", int'(status_code), 'hF8);
        check_eq("R11 reset irq", int'(irq), 0);
        check_eq("R11 reset req", int'(eng_req), 0);
        check_eq("R11 reset count", int'(xfer_count), 0);

        // R1 start without enable is ignored
        mark = log_n;
        ctl_write(4'b0010);
        repeat (10) @(negedge clk);
        check_eq("R1 no command when disabled", log_n - mark, 0);
        check_eq("R1 status unchanged", int'(status_code), 'hF8);

        // R9 count write resets pointer; R2/R4 single byte tx
        lat = 1;
        cnt_write(3, 1'b0);
        buf_load(8'hAA);
        buf_load(8'hBB);
        cnt_write(1, 1'b0);
        buf_load(8'h42);
        do_start(1'b0);
        mark = log_n;
        ctl_write(4'b0001);
        wait_irq("R9");
        check_eq("R9 first byte after pointer reset", int'(log_dat[mark]), 'h42);
        check_eq("R4 single tx status", int'(status_code), 'h28);

        // R1 disabled stop while holding is ignored
        mark = log_n;
        ctl_write(4'b0100);
        repeat (10) @(negedge clk);
        check_eq("R1 disabled stop no command", log_n - mark, 0);
        check_eq("R1 irq kept", int'(irq), 1);

        // R10 stop write in the same cycle as the final acknowledge
        cnt_write(1, 1'b0);
        buf_load(8'h5C);
        lat = 2;
        mark = log_n;
        ctl_write(4'b0001);
        while (!eng_ack) @(negedge clk);
        host_ctl_wr = 1'b1; host_ctl_data = 4'b0101;
        @(negedge clk);
        host_ctl_wr = 1'b0;
        wait_irq("R10");
        repeat (8) @(negedge clk);
        check_eq("R10 status after collision", int'(status_code), 'h28);
        check_eq("R10 no stop issued", log_n - mark, 1);
        check_eq("R10 irq raised", int'(irq), 1);

        // R13 start and stop together -> stop
        mark = log_n;
        ctl_write(4'b0111);
        repeat (12) @(negedge clk);
        check_eq("R13 stop wins cmd", int'(log_cmd[mark]), 5);
        check_eq("R13 status idle", int'(status_code), 'hF8);

        // R8 address nack on a read
        do_start(1'b0);
        do_rx(3, 1'b0, 1'b1, 1'b1);
        do_stop();

        // constrained random runs
        owned = 1'b0;
        for (int it = 0; it < 30; it++) begin
            int c;
            int k;
            bit last;
            lat = $urandom % 4;
            do_start(owned);
            owned = 1'b1;
            if ($urandom % 2 == 0) begin
                c = 1 + $urandom % 8;
                k = ($urandom % 3 == 0) ? int'($urandom % c) : -1;
                do_tx(c, k, 1'b1, nk);
                if (!nk && ($urandom % 2 == 1)) begin
                    c = 1 + $urandom % 6;
                    k = ($urandom % 3 == 0) ? int'($urandom % c) : -1;
                    do_tx(c, k, 1'b0, nk);
                end
                if (nk) begin do_stop(); owned = 1'b0; end
            end else begin
                c = 1 + $urandom % 8;
                last = 1'($urandom % 2);
                do_rx(c, last, 1'b1, 1'b0);
                if (!last && ($urandom % 2 == 1))
                    do_rx(1 + $urandom % 6, 1'($urandom % 2), 1'b0, 1'b0);
            end
            if (owned && ($urandom % 2 == 1)) begin do_stop(); owned = 1'b0; end
        end
        if (owned) do_stop();

        summary_and_end();
    end

endmodule